// File: doc/BRIEF.md
# Clock-Chip Time Snapshot Sequencer

This block controls a real-time clock chip whose registers are four bits wide. It sits above a serial master and runs one whole time read or time write on each request. Every register access goes through the serial master's command port. The sequencer issues one command, then waits for the master's completion pulse before it issues the next.

A read or write begins with a handshake. The sequencer raises the chip enable, sets the chip's control register to 24-hour operation, and reads that register back. While the busy flag reads as set, the sequencer drops the chip enable, waits for a fixed gap and tries again. The number of retries is bounded. Once the flag reads clear, the seven time fields move as BCD nibbles. Each field has a units register at an even address and a tens register at the next odd address. The weekday is the exception: it has a units register only. The fields are presented as assembled BCD bytes on a parallel time bus.

A third request checks the oscillator-stop flag. If the flag is set, the sequencer re-initialises the chip and loads a default date. The block holds one busy output and one sticky error flag, which reports a timeout.

Top module: `clkchip_seq`

## Requirements
- R1: When a read or write request is accepted, `chip_en` rises. The first two commands are a write of 0x4 to control address 0xE, then a read of address 0xE.
- R2: If bit 0 (busy) of that control read is 1, `chip_en` goes low for exactly GAP_CYC cycles. The attempt then repeats from the control write, with `chip_en` high again.
- R3: If busy reads as 1 on the first attempt and on each of RETRY_LIMIT retries, the operation ends with `err` set. In that case no time register is accessed and `rd_time` keeps its value.
- R4: A read accesses the registers in this order: 0x0, 0x1 (seconds); 0x2, 0x3 (minutes); 0x4, 0x5 (hours); 0x8, 0x9 (day); 0xA, 0xB (month); 0xC, 0xD (year); 0x6 (weekday). Units are at the even address and tens at the odd address. Nibble k of `rd_time` (bits 4k+3:4k) holds the k-th value read, and bits 55:52 are zero. `rd_time` changes only at the end of a successful read.
- R5: A write uses the same address order as R4. It writes nibble k of the `wr_time` value captured in the cycle the request is accepted; bits 55:52 are not used.
- R6: After the last access, `chip_en` falls and `busy` stays high for exactly GAP_CYC more cycles. `chip_en` is low whenever `busy` is low.
- R7: A check request first reads address 0xE. If bit 1 (stop flag) is 0, the operation ends. If it is 1, the sequencer writes 0x0 to address 0x7 and 0x7 to address 0xE. It then reads 0xE until bit 0 is 0, at most RETRY_LIMIT+1 times. Finally it runs a write (R1, R2, R5) of the time 0x00_00_01_01_00_00_00, which is day 01, month 01 and all other fields 00.
- R8: `cmd_valid` is a one-cycle pulse and occurs only while `chip_en` is high. No new command is issued until `cmd_done` has answered the previous one.
- R9: Requests that arrive while `busy` is high are ignored. If requests arrive together, a read is taken before a write, and a write before a check.
- R10: `err` is sticky. It clears in the cycle after the next request is accepted.
- R11: After reset, `busy`, `err`, `chip_en` and `cmd_valid` are 0 and `rd_time` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_read | input | 1 | Start a time read |
| req_write | input | 1 | Start a time write |
| req_check | input | 1 | Start an oscillator-stop check |
| wr_time | input | 56 | BCD time to write: weekday, year, month, day, hour, minute, second from the top byte down |
| rd_time | output | 56 | Last successfully read BCD time, same layout |
| busy | output | 1 | An operation is in progress |
| err | output | 1 | Sticky timeout flag |
| chip_en | output | 1 | Chip enable to the clock chip |
| cmd_valid | output | 1 | One-cycle command strobe to the serial master |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_addr | output | 4 | Chip register address |
| cmd_wdata | output | 4 | Nibble to write (0 on reads) |
| cmd_done | input | 1 | Serial master completion pulse |
| cmd_rdata | input | 4 | Nibble returned by a read, valid with cmd_done |

## Verification
The assertions check on every cycle the properties that hold regardless of data:
- the command strobe is a single-cycle pulse;
- commands occur only under chip enable, and chip enable is off while idle;
- the error flag clears when a request is accepted;
- `rd_time` moves only as busy falls;
- the retry count stays in bound;
- the gap timer is never re-armed while it is running.

Only the bench's scenarios can show that the exact command sequence is correct. That covers address order, the nibble values carried, the number of attempts before success or timeout, the length of each gap measured at the pins, and the assembled read value. It also covers the check-stop re-initialisation and the handling of requests that arrive while the block is busy or at the same time.

// File: rtl/clkchip_pkg.sv
package clkchip_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHK_RD,
    ST_CHK_CLRINT,
    ST_CHK_SETCTL,
    ST_CHK_POLL,
    ST_ATT_WCTL,
    ST_ATT_RCTL,
    ST_RETRY_GAP,
    ST_XFER,
    ST_SETTLE
  } seq_state_t;

  localparam logic [3:0] CTL_ADDR  = 4'hE;
  localparam logic [3:0] INTV_ADDR = 4'h7;
  localparam logic [3:0] CTL_RUN   = 4'h4;
  localparam logic [3:0] CTL_INIT  = 4'h7;
  localparam int         BUSY_BIT  = 0;
  localparam int         STOP_BIT  = 1;

  // Register address of transfer step k: the field is k/2, and odd k selects tens.
  function automatic logic [3:0] step_addr(input logic [3:0] step);
    logic [3:0] base;
    case (step[3:1])
      3'd0:    base = 4'h0;
      3'd1:    base = 4'h2;
      3'd2:    base = 4'h4;
      3'd3:    base = 4'h8;
      3'd4:    base = 4'hA;
      3'd5:    base = 4'hC;
      default: base = 4'h6;
    endcase
    return base | {3'b000, step[0]};
  endfunction

  // Bit offset of the nibble for step k inside the time frame.
  function automatic logic [5:0] step_lsb(input logic [3:0] step);
    return {step, 2'b00};
  endfunction

endpackage

// File: rtl/clkchip_retry_ctr.sv
module clkchip_retry_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc && !at_limit)
      cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT));

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT)); // R3

endmodule

// File: rtl/clkchip_gap_timer.sv
module clkchip_gap_timer #(
  parameter int GAP_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic done
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (kick) begin
      cnt <= GW'(GAP_CYC);
      run <= 1'b1;
    end else if (run) begin
      cnt <= cnt - 1'b1;
      if (cnt == GW'(1)) run <= 1'b0;
    end
  end

  assign done = run && (cnt == GW'(1));

  AST_GAP_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !run); // R2

endmodule

// File: rtl/clkchip_field_map.sv
module clkchip_field_map #(
  parameter int FIELDS = 7
) (
  input  logic [3:0]          step,
  input  logic [8*FIELDS-1:0] frame,
  output logic [3:0]          addr,
  output logic [3:0]          wdata,
  output logic                last
);
  import clkchip_pkg::*;

  localparam int STEPS = 2 * FIELDS - 1;

  assign addr  = step_addr(step);
  assign wdata = frame[step_lsb(step) +: 4];
  assign last  = (step == 4'(STEPS - 1));

endmodule

// File: rtl/clkchip_seq.sv
module clkchip_seq #(
  parameter int RETRY_LIMIT = 100,
  parameter int GAP_CYC     = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_read,
  input  logic        req_write,
  input  logic        req_check,
  input  logic [55:0] wr_time,
  output logic [55:0] rd_time,
  output logic        busy,
  output logic        err,
  output logic        chip_en,
  output logic        cmd_valid,
  output logic        cmd_write,
  output logic [3:0]  cmd_addr,
  output logic [3:0]  cmd_wdata,
  input  logic        cmd_done,
  input  logic [3:0]  cmd_rdata
);
  import clkchip_pkg::*;

  localparam int FIELDS = 7;
  localparam int TW     = 8 * FIELDS;
  localparam logic [TW-1:0] DEFAULT_TIME = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  seq_state_t    state;
  logic          outstanding;
  logic          op_read;
  logic [3:0]    step;
  logic [TW-1:0] frame;
  logic [TW-1:0] rd_time_q;
  logic          err_q;

  // Named internal events
  logic       is_access;
  logic       acc_done;
  logic       ctl_busy;
  logic       ctl_stop;
  logic       retry_clr;
  logic       retry_inc;
  logic       at_limit;
  logic       gap_kick;
  logic       gap_done;
  logic       any_req;
  logic [3:0] map_addr;
  logic [3:0] map_wdata;
  logic       map_last;

  clkchip_retry_ctr #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (retry_clr),
    .inc      (retry_inc),
    .at_limit (at_limit)
  );

  clkchip_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (gap_kick),
    .done  (gap_done)
  );

  clkchip_field_map #(.FIELDS(FIELDS)) u_map (
    .step  (step),
    .frame (frame),
    .addr  (map_addr),
    .wdata (map_wdata),
    .last  (map_last)
  );

  assign any_req  = req_read || req_write || req_check;
  assign ctl_busy = cmd_rdata[BUSY_BIT];
  assign ctl_stop = cmd_rdata[STOP_BIT];
  assign acc_done = outstanding && cmd_done;

  // Command decode per access state
  always_comb begin
    is_access = 1'b1;
    cmd_write = 1'b0;
    cmd_addr  = CTL_ADDR;
    cmd_wdata = 4'h0;
    case (state)
      ST_CHK_RD:     ;
      ST_CHK_CLRINT: begin cmd_write = 1'b1; cmd_addr = INTV_ADDR; end
      ST_CHK_SETCTL: begin cmd_write = 1'b1; cmd_wdata = CTL_INIT; end
      ST_CHK_POLL:   ;
      ST_ATT_WCTL:   begin cmd_write = 1'b1; cmd_wdata = CTL_RUN; end
      ST_ATT_RCTL:   ;
      ST_XFER: begin
        cmd_write = !op_read;
        cmd_addr  = map_addr;
        cmd_wdata = op_read ? 4'h0 : map_wdata;
      end
      default: is_access = 1'b0;
    endcase
  end

  assign cmd_valid = is_access && !outstanding;
  assign chip_en   = is_access;
  assign busy      = (state != ST_IDLE);
  assign err       = err_q;
  assign rd_time   = rd_time_q;

  assign retry_clr = (state == ST_IDLE && any_req) ||
                     (acc_done && state == ST_CHK_SETCTL) ||
                     (acc_done && state == ST_CHK_POLL && (!ctl_busy || at_limit));
  assign retry_inc = acc_done && ctl_busy &&
                     (state == ST_ATT_RCTL || state == ST_CHK_POLL);
  assign gap_kick  = acc_done && ((state == ST_ATT_RCTL && ctl_busy) ||
                                  (state == ST_XFER && map_last) ||
                                  (state == ST_CHK_RD && !ctl_stop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      outstanding <= 1'b0;
    else if (cmd_valid)
      outstanding <= 1'b1;
    else if (cmd_done)
      outstanding <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_read   <= 1'b0;
      step      <= '0;
      frame     <= '0;
      rd_time_q <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_read) begin
            op_read <= 1'b1;
            frame   <= '0;
            err_q   <= 1'b0;
            state   <= ST_ATT_WCTL;
          end else if (req_write) begin
            op_read <= 1'b0;
            frame   <= wr_time;
            err_q   <= 1'b0;
            state   <= ST_ATT_WCTL;
          end else if (req_check) begin
            op_read <= 1'b0;
            frame   <= DEFAULT_TIME;
            err_q   <= 1'b0;
            state   <= ST_CHK_RD;
          end
        end
        ST_CHK_RD:
          if (acc_done) state <= ctl_stop ? ST_CHK_CLRINT : ST_SETTLE;
        ST_CHK_CLRINT:
          if (acc_done) state <= ST_CHK_SETCTL;
        ST_CHK_SETCTL:
          if (acc_done) state <= ST_CHK_POLL;
        ST_CHK_POLL:
          if (acc_done && (!ctl_busy || at_limit)) state <= ST_ATT_WCTL;
        ST_ATT_WCTL:
          if (acc_done) state <= ST_ATT_RCTL;
        ST_ATT_RCTL:
          if (acc_done) begin
            if (!ctl_busy) begin
              step  <= '0;
              state <= ST_XFER;
            end else if (at_limit) begin
              err_q <= 1'b1;
              state <= ST_SETTLE;
            end else begin
              state <= ST_RETRY_GAP;
            end
          end
        ST_RETRY_GAP:
          if (gap_done) state <= ST_ATT_WCTL;
        ST_XFER:
          if (acc_done) begin
            if (op_read) frame[step_lsb(step) +: 4] <= cmd_rdata;
            if (map_last) state <= ST_SETTLE;
            else          step  <= step + 1'b1;
          end
        ST_SETTLE:
          if (gap_done) begin
            if (op_read && !err_q) rd_time_q <= frame;
            state <= ST_IDLE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R8
  AST_CMD_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> chip_en); // R8
  AST_IDLE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !chip_en); // R6
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && any_req) |=> !err); // R10
  AST_ERR_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !chip_en); // R3
  AST_RDTIME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_time) |-> ($past(busy) && !busy)); // R4

endmodule

// File: tb/sim_clkchip_seq.sv
module sim_clkchip_seq;
  localparam int LIM = 3;
  localparam int GAP = 5;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_read = 1'b0, req_write = 1'b0, req_check = 1'b0;
  logic [55:0] wr_time = '0;
  logic [55:0] rd_time;
  logic        busy, err, chip_en, cmd_valid, cmd_write;
  logic [3:0]  cmd_addr, cmd_wdata;
  logic        cmd_done = 1'b0;
  logic [3:0]  cmd_rdata = 4'h0;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  logic [3:0] regs [16];
  int busy_left = 0;
  logic stop_flag = 1'b0;
  logic [8:0] exp_q [$];
  int adr_tab [13] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 6};

  always #10 clk = ~clk;

  clkchip_seq #(.RETRY_LIMIT(LIM), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_read(req_read), .req_write(req_write),
    .req_check(req_check), .wr_time(wr_time), .rd_time(rd_time), .busy(busy),
    .err(err), .chip_en(chip_en), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Driver side of the scoreboard
  task automatic push_attempts(input int busy_n);
    for (int i = 0; i <= busy_n; i++) begin
      exp_q.push_back({1'b1, 4'hE, 4'h4});
      exp_q.push_back({1'b0, 4'hE, 4'h0});
    end
  endtask

  task automatic push_xfer(input bit wr, input logic [55:0] t);
    for (int k = 0; k < 13; k++)
      exp_q.push_back({wr, 4'(adr_tab[k]), wr ? t[4*k +: 4] : 4'h0});
  endtask

  task automatic pulse(input bit r, input bit w, input bit c);
    @(negedge clk);
    req_read = r; req_write = w; req_check = c;
    @(negedge clk);
    req_read = 0; req_write = 0; req_check = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, cur_tag, busy, 0);
    chk(exp_q.size() == 0, cur_tag, exp_q.size(), 0);
  endtask

  task automatic load_regs(input logic [55:0] t);
    for (int k = 0; k < 13; k++) regs[adr_tab[k]] = t[4*k +: 4];
  endtask

  task automatic check_regs(input logic [55:0] t, input string tag);
    for (int k = 0; k < 13; k++)
      chk(regs[adr_tab[k]] == t[4*k +: 4], tag, regs[adr_tab[k]], t[4*k +: 4]);
  endtask

  // Serial master model and monitor side of the scoreboard
  initial begin
    int lat_cnt = 0;
    int gcnt = 0;
    logic [3:0] resp = 4'h0;
    logic [8:0] got, want;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          cmd_done  = 1'b1;
          cmd_rdata = resp;
        end
      end
      if (cmd_valid) begin
        // R8: a command only after the previous one was answered, with chip enable high
        chk(lat_cnt == 0 && chip_en, "R8", {lat_cnt[7:0], chip_en}, 1);
        got = {cmd_write, cmd_addr, cmd_wdata};
        if (exp_q.size() == 0) begin
          chk(0, cur_tag, got, 0);
        end else begin
          want = exp_q.pop_front();
          chk(got == want, cur_tag, got, want);
        end
        if (cmd_write) begin
          regs[cmd_addr] = cmd_wdata;
          if (cmd_addr == 4'hE && cmd_wdata == 4'h7) stop_flag = 1'b0;
          resp = 4'h0;
        end else if (cmd_addr == 4'hE) begin
          resp = {2'b00, stop_flag, busy_left != 0};
          if (busy_left > 0) busy_left--;
        end else begin
          resp = regs[cmd_addr];
        end
        lat_cnt = LAT;
      end
      // R2 / R6: length of every chip-enable-low window inside an operation
      if (busy && !chip_en) gcnt++;
      else if (gcnt > 0) begin
        chk(gcnt == GAP, "R2 R6 gap", gcnt, GAP);
        gcnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [55:0] t_a, t_b, t_def;
    t_a   = 56'h06_99_12_31_23_59_58;
    t_b   = 56'h03_24_07_15_12_34_56;
    t_def = 56'h00_00_01_01_00_00_00;
    for (int i = 0; i < 16; i++) regs[i] = 4'h0;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !err && !chip_en && !cmd_valid, "R11", {busy, err, chip_en, cmd_valid}, 0);
    chk(rd_time == 0, "R11", rd_time, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4: plain read
    cur_tag = "R4 read";
    load_regs(t_a);
    push_attempts(0);
    push_xfer(0, 0);
    pulse(1, 0, 0);
    chk(chip_en, "R1", chip_en, 1);
    wait_idle();
    chk(rd_time == t_a, "R4", rd_time, t_a);
    chk(!err, "R4", err, 0);

    // R2: read succeeding after two busy attempts
    cur_tag = "R2 retry";
    busy_left = 2;
    push_attempts(2);
    push_xfer(0, 0);
    pulse(1, 0, 0);
    wait_idle();
    chk(rd_time == t_a && !err, "R2", {err, rd_time}, {1'b0, t_a});

    // R5 R9: write at the retry limit, wr_time changed after acceptance, read request while busy
    cur_tag = "R5 write";
    busy_left = LIM;
    wr_time = t_b;
    push_attempts(LIM);
    push_xfer(1, t_b);
    pulse(0, 1, 0);
    wr_time = 56'hFF_FF_FF_FF_FF_FF_FF;
    pulse(1, 0, 1);
    wait_idle();
    check_regs(t_b, "R5");
    chk(!err, "R5", err, 0);
    chk(rd_time == t_a, "R9", rd_time, t_a);

    // R3: timeout
    cur_tag = "R3 timeout";
    busy_left = LIM + 1;
    push_attempts(LIM);
    pulse(1, 0, 0);
    wait_idle();
    chk(err, "R3", err, 1);
    chk(rd_time == t_a, "R3", rd_time, t_a);

    // R10: error clears on next request; read back written time
    cur_tag = "R10 read";
    busy_left = 0;
    push_attempts(0);
    push_xfer(0, 0);
    pulse(1, 0, 0);
    chk(!err, "R10", err, 0);
    wait_idle();
    chk(rd_time == t_b, "R4 R10", rd_time, t_b);

    // R7: check with stop flag clear
    cur_tag = "R7 check clear";
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    pulse(0, 0, 1);
    wait_idle();
    check_regs(t_b, "R7");

    // R7: check with stop flag set
    cur_tag = "R7 check set";
    stop_flag = 1'b1;
    regs[7] = 4'h9;
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    exp_q.push_back({1'b1, 4'h7, 4'h0});
    exp_q.push_back({1'b1, 4'hE, 4'h7});
    exp_q.push_back({1'b0, 4'hE, 4'h0});
    push_attempts(0);
    push_xfer(1, t_def);
    pulse(0, 0, 1);
    wait_idle();
    check_regs(t_def, "R7");
    chk(regs[7] == 4'h0, "R7", regs[7], 0);

    // R9: simultaneous read and write takes the read
    cur_tag = "R9 priority";
    load_regs(t_a);
    wr_time = t_b;
    push_attempts(0);
    push_xfer(0, 0);
    pulse(1, 1, 0);
    wait_idle();
    chk(rd_time == t_a, "R9", rd_time, t_a);
    check_regs(t_a, "R9");

    repeat (5) @(negedge clk);
    summary();
  end

endmodule